// File: doc/BRIEF.md
# Serial Step-Attenuator Programmer

This block sits between a simple request port and a bank of digital step attenuators that take their setting over a serial line. Every attenuator chip shares one data wire and one shift clock. Each chip has its own latch strobe. A request names a channel, a stage within that channel and an attenuation in quarter-dB. The block validates the request and turns the value into whole dB. It shifts the six-bit control word out most significant bit first, with one clock pulse per bit. It then raises the strobe of the addressed chip alone, so the new setting takes effect.

The block keeps the setting now applied to every chip. A read request returns either that applied value or a fixed power-on value, both in quarter-dB. Bad requests are answered with a status code and cause no serial activity. Each phase of the serial waveform (clock low, clock high, strobe high) lasts `PULSE_CYC` system clocks. The integrator sets this count so that the chips' minimum pulse width of 30 ns is met.

Top module: `step_atten_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `req_ready` is 1. `ser_clk`, `ser_data`, `latch` and `done` are 0, and every chip's applied value reads as 0.
- R2: An accepted write applies the whole-dB value `req_qdb / 4`, with the fraction dropped. Its done reports status 0 (OK) with `rd_qdb` equal to that whole-dB value times 4, and a later read of the applied value returns the same number.
- R3: A write whose whole-dB value exceeds 31 (`req_qdb` of 128 or more) completes with status 2 (range). It produces no clock pulse, no data and no strobe, and the chip's applied value is left unchanged.
- R4: A request with `req_chan >= NUM_CH` or `req_stage >= NUM_STG` completes with status 1 (no device), for writes and reads alike, with no serial activity. This check takes priority over the range and selector checks.
- R5: The control word is 6 bits, sent most significant bit first, so its top bit is 0. Each bit is placed on `ser_data` while `ser_clk` is low, then `ser_clk` is high for `PULSE_CYC` cycles, and `ser_data` does not change while `ser_clk` is high. Each low phase also lasts `PULSE_CYC` cycles, and `ser_data` is 0 outside shifting.
- R6: After the sixth clock pulse, only the strobe bit `latch[chan*NUM_STG + stage]` goes high, for `PULSE_CYC` cycles, with `ser_clk` low. All strobes stay low while bits are being shifted.
- R7: A read with `req_sel` = 0 returns the applied value, and one with `req_sel` = 1 returns `STARTUP_QDB`, both with status 0. Any other selector returns status 3 (invalid argument).
- R8: A request is accepted when `req_valid` and `req_ready` are both high. Reads and rejected requests raise `done` for one cycle right after the accepting edge. An accepted write drops `req_ready` until it finishes, then raises `done` `13*PULSE_CYC` cycles after the accepting edge, and `req_ready` returns in that same cycle. `rd_qdb` is 0 on every done whose status is not OK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_write | input | 1 | 1 = program a chip, 0 = read back |
| req_chan | input | CH_W | Channel index |
| req_stage | input | ST_W | Stage index within the channel |
| req_qdb | input | 8 | Requested attenuation in quarter-dB (writes) |
| req_sel | input | 2 | Read selector: 0 applied, 1 power-on |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 OK, 1 no device, 2 range, 3 invalid selector |
| rd_qdb | output | 8 | Result value in quarter-dB |
| ser_data | output | 1 | Shared serial data |
| ser_clk | output | 1 | Shared serial shift clock |
| latch | output | NUM_CH*NUM_STG | Per-chip latch strobes |

## Verification
The write path is driven with values whose whole-dB words have distinct bit patterns: 0, an alternating 001010, the maximum 31, and values with a fractional quarter that must be dropped. A swapped, repeated or misplaced bit therefore shows up on `ser_data`. Writes to chips at opposite corners of the bank separate a correct strobe index from a mirrored or fixed one. The values 127 and 128 mark the edge of the range check. Out-of-range channels and stages, read with both selectors and with the two invalid selectors, exercise every error code. A read held pending across a busy write confirms that it waits, and that it sees the value just applied.

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl #(
  parameter int NUM_CH = 4,
  parameter int NUM_STG = 2,
  parameter int PULSE_CYC = 2,
  parameter logic [7:0] STARTUP_QDB = 8'd80,
  localparam int CHIPS = NUM_CH * NUM_STG,
  localparam int CH_W = $clog2(NUM_CH + 1),
  localparam int ST_W = $clog2(NUM_STG + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [CH_W-1:0]  req_chan,
  input  logic [ST_W-1:0]  req_stage,
  input  logic [7:0]       req_qdb,
  input  logic [1:0]       req_sel,
  output logic             done,
  output logic [1:0]       status,
  output logic [7:0]       rd_qdb,
  output logic             ser_data,
  output logic             ser_clk,
  output logic [CHIPS-1:0] latch
);
  localparam int IW = (CHIPS > 1) ? $clog2(CHIPS) : 1;
  localparam int PW = $clog2(PULSE_CYC + 1);
  localparam logic [1:0] ST_OK = 2'd0, ST_NODEV = 2'd1, ST_RANGE = 2'd2, ST_INVAL = 2'd3;

  logic          busy, hi, lat;
  logic [PW-1:0] cnt;
  logic [2:0]    bitn;
  logic [5:0]    word_q;
  logic [IW-1:0] chip_q;
  logic [7:0]    cur_q [CHIPS];

  logic          addr_ok, range_ok, sel_ok, phase_end;
  logic [IW-1:0] req_idx;

  assign addr_ok   = (int'(req_chan) < NUM_CH) && (int'(req_stage) < NUM_STG);
  assign range_ok  = !req_qdb[7];
  assign sel_ok    = (req_sel < 2'd2);
  assign req_idx   = IW'(int'(req_chan) * NUM_STG + int'(req_stage));
  assign phase_end = (cnt == PW'(PULSE_CYC - 1));

  assign req_ready = !busy;
  assign ser_clk   = busy && hi && !lat;
  assign ser_data  = busy && !lat && word_q[3'd5 - bitn];
  assign latch     = (busy && lat) ? (CHIPS'(1) << chip_q) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; hi <= 1'b0; lat <= 1'b0; cnt <= '0; bitn <= '0;
      word_q <= '0; chip_q <= '0; done <= 1'b0; status <= ST_OK; rd_qdb <= '0;
      for (int i = 0; i < CHIPS; i++) cur_q[i] <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          if (!addr_ok) begin
            done <= 1'b1; status <= ST_NODEV; rd_qdb <= '0;
          end else if (req_write) begin
            if (!range_ok) begin
              done <= 1'b1; status <= ST_RANGE; rd_qdb <= '0;
            end else begin
              busy <= 1'b1; hi <= 1'b0; lat <= 1'b0; cnt <= '0; bitn <= '0;
              word_q <= req_qdb[7:2]; chip_q <= req_idx;
            end
          end else if (!sel_ok) begin
            done <= 1'b1; status <= ST_INVAL; rd_qdb <= '0;
          end else begin
            done <= 1'b1; status <= ST_OK;
            rd_qdb <= (req_sel == 2'd0) ? cur_q[req_idx] : STARTUP_QDB;
          end
        end
      end else if (!phase_end) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        if (lat) begin
          busy <= 1'b0; lat <= 1'b0; done <= 1'b1; status <= ST_OK;
          rd_qdb <= {word_q, 2'b00};
          cur_q[chip_q] <= {word_q, 2'b00};
        end else if (!hi) begin
          hi <= 1'b1;
        end else begin
          hi <= 1'b0;
          if (bitn == 3'd5) lat <= 1'b1;
          else bitn <= bitn + 1'b1;
        end
      end
    end
  end

  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(latch));
  p_strobe_clk_low_r6: assert property (@(posedge clk) disable iff (!rst_n) (|latch) |-> !ser_clk);
  p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n) ser_clk |-> $stable(ser_data));
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n) done |-> req_ready);
  p_write_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && addr_ok && range_ok) |=> !req_ready);
  p_reject_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && addr_ok && !range_ok) |=> (req_ready && !ser_clk && latch == '0));
  p_nodev_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !addr_ok) |=> (done && status == ST_NODEV));
endmodule

// File: tb/step_atten_ctrl_test.sv
module step_atten_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int NST = 2;
  localparam int P = 3;
  localparam int SUQ = 80;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [2:0] req_chan = 0;
  logic [1:0] req_stage = 0;
  logic [7:0] req_qdb = 0;
  logic [1:0] req_sel = 0;
  logic req_ready, done, ser_data, ser_clk;
  logic [1:0] status;
  logic [7:0] rd_qdb;
  logic [NCH*NST-1:0] latch;

  int checks = 0, fails = 0;
  bit finished = 0;

  step_atten_ctrl #(.NUM_CH(NCH), .NUM_STG(NST), .PULSE_CYC(P), .STARTUP_QDB(8'(SUQ))) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_chan(req_chan), .req_stage(req_stage),
    .req_qdb(req_qdb), .req_sel(req_sel), .done(done), .status(status),
    .rd_qdb(rd_qdb), .ser_data(ser_data), .ser_clk(ser_clk), .latch(latch));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_busy, m_done, m_acc;
  int m_t, m_whole, m_chip, m_st, m_rd;
  int m_cur [NCH*NST];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 0; m_done <= 0; m_acc <= 0; m_t <= 0; m_st <= 0; m_rd <= 0;
      for (int i = 0; i < NCH*NST; i++) m_cur[i] <= 0;
    end else begin
      m_done <= 0; m_acc <= 0;
      if (m_busy) begin
        if (m_t == 13*P - 1) begin
          m_busy <= 0; m_done <= 1; m_st <= 0; m_rd <= m_whole*4;
          m_cur[m_chip] <= m_whole*4;
        end else m_t <= m_t + 1;
      end else if (req_valid) begin
        m_acc <= 1;
        if (int'(req_chan) >= NCH || int'(req_stage) >= NST) begin
          m_done <= 1; m_st <= 1; m_rd <= 0;
        end else if (req_write) begin
          if (int'(req_qdb) / 4 > 31) begin
            m_done <= 1; m_st <= 2; m_rd <= 0;
          end else begin
            m_busy <= 1; m_t <= 0; m_whole <= int'(req_qdb) / 4;
            m_chip <= int'(req_chan) * NST + int'(req_stage);
          end
        end else if (req_sel > 1) begin
          m_done <= 1; m_st <= 3; m_rd <= 0;
        end else begin
          m_done <= 1; m_st <= 0;
          m_rd <= (req_sel == 0) ? m_cur[int'(req_chan) * NST + int'(req_stage)] : SUQ;
        end
      end
    end
  end

  always @(negedge clk) begin
    int e_clk, e_data, e_latch, b;
    string stag;
    e_clk = 0; e_data = 0; e_latch = 0;
    if (m_busy) begin
      if (m_t < 12*P) begin
        b = 5 - m_t / (2*P);
        e_clk = ((m_t % (2*P)) >= P);
        e_data = (m_whole >> b) & 1;
      end else e_latch = 1 << m_chip;
    end
    chk(req_ready == !m_busy, rst_n ? "R8" : "R1", "req_ready", req_ready, !m_busy);
    chk(done == m_done, rst_n ? "R8" : "R1", "done", done, m_done);
    chk(ser_clk == e_clk, rst_n ? "R5" : "R1", "ser_clk", ser_clk, e_clk);
    chk(ser_data == e_data, rst_n ? "R5" : "R1", "ser_data", ser_data, e_data);
    chk(int'(latch) == e_latch, rst_n ? "R6" : "R1", "latch", latch, e_latch);
    if (m_done) begin
      case (m_st)
        1: stag = "R4";
        2: stag = "R3";
        3: stag = "R7";
        default: stag = "R2";
      endcase
      chk(int'(status) == m_st, stag, "status", status, m_st);
      chk(int'(rd_qdb) == m_rd, stag, "rd_qdb", rd_qdb, m_rd);
    end
  end

  task automatic req(input bit wr, input int ch, input int stg, input int qdb, input int sel,
                     output int st, output int rd);
    req_valid = 1; req_write = wr; req_chan = 3'(ch); req_stage = 2'(stg);
    req_qdb = 8'(qdb); req_sel = 2'(sel);
    do @(negedge clk); while (!m_acc);
    req_valid = 0;
    while (!done) @(negedge clk);
    st = status; rd = rd_qdb;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int st, rd, cyc;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    req(0, 1, 1, 0, 0, st, rd);
    chk(st == 0 && rd == 0, "R1", "applied value after reset", rd, 0);

    req(1, 0, 0, 123, 0, st, rd);
    chk(rd == 120, "R2", "write 123 qdB", rd, 120);
    req(0, 0, 0, 0, 0, st, rd);
    chk(rd == 120, "R2", "readback ch0 st0", rd, 120);

    req(1, 3, 1, 124, 0, st, rd);
    chk(rd == 124, "R2", "write max", rd, 124);
    req(1, 3, 1, 127, 0, st, rd);
    chk(rd == 124, "R2", "fraction dropped at 127", rd, 124);

    req(1, 3, 1, 128, 0, st, rd);
    chk(st == 2, "R3", "range at 128", st, 2);
    req(1, 3, 1, 255, 0, st, rd);
    chk(st == 2, "R3", "range at 255", st, 2);
    req(0, 3, 1, 0, 0, st, rd);
    chk(rd == 124, "R3", "value kept after range error", rd, 124);

    req(1, 4, 0, 8, 0, st, rd);
    chk(st == 1, "R4", "write chan 4", st, 1);
    req(1, 1, 2, 200, 0, st, rd);
    chk(st == 1, "R4", "stage 2 beats range", st, 1);
    req(0, 7, 0, 0, 3, st, rd);
    chk(st == 1, "R4", "read chan 7 beats selector", st, 1);

    req(0, 2, 1, 0, 1, st, rd);
    chk(st == 0 && rd == SUQ, "R7", "startup value", rd, SUQ);
    req(0, 2, 1, 0, 2, st, rd);
    chk(st == 3, "R7", "selector 2", st, 3);
    req(0, 2, 1, 0, 3, st, rd);
    chk(st == 3, "R7", "selector 3", st, 3);

    req(1, 2, 0, 42, 0, st, rd);
    chk(rd == 40, "R5", "alternating word 001010", rd, 40);
    req(1, 1, 0, 0, 0, st, rd);
    chk(rd == 0, "R2", "write zero", rd, 0);

    // write followed by a read held pending while busy
    req_valid = 1; req_write = 1; req_chan = 3'd1; req_stage = 2'd1; req_qdb = 8'd86;
    do @(negedge clk); while (!m_acc);
    req_write = 0; req_sel = 2'd0; cyc = 0;
    do begin @(negedge clk); cyc++; end while (!m_acc);
    req_valid = 0;
    chk(cyc == 13*P + 1, "R8", "pending read accepted after write", cyc, 13*P + 1);
    chk(done && rd_qdb == 84, "R8", "pending read sees new value", rd_qdb, 84);
    repeat (3) @(negedge clk);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule